// File: doc/BRIEF.md
# Indexed Pixel Scanout with Start-Offset Panning

This block walks an 8-bit-per-pixel frame buffer in raster order and turns each stored byte into a 24-bit colour through a 256-entry palette. Each frame starts at a programmable byte offset. Moving that offset by a whole number of lines scrolls the picture vertically, and no data has to be copied. The block runs from the pixel clock. It issues one frame buffer read per pixel, and the read returns its data one cycle later. It then presents colour with a valid strobe and with markers for the last pixel of a line and the last pixel of a frame.

The width, height, start offset, blank control and depth code are captured once, in a single idle cycle ahead of every frame. Software can therefore change them at any time without tearing the frame in progress. When the blank control is captured, the block walks the frame and outputs black without reading memory. A frame with a zero dimension or an unsupported depth code is not drawn. At the end of each drawn frame the block raises an interrupt, which stays high until the next register or palette write.

Top module: `index_scanout`

## Requirements
- R1: While a non-blank frame is drawn, `fb_rd_o` is high for each pixel and `fb_addr_o` equals offset + y*width + x, one byte per pixel, with x running fastest.
- R2: For each non-blank pixel, `rgb_o` equals the palette entry selected by the fetched byte. An entry holds red in bits 23:16, green in 15:8 and blue in 7:0, and is written through `pal_we_i`, `pal_idx_i` and `pal_rgb_i`.
- R3: In a frame captured with `blank_i` high, every valid pixel has `rgb_o` equal to zero and `fb_rd_o` stays low for the whole frame.
- R4: If the captured width or height is zero, the block produces no valid pixel, no read and no interrupt.
- R5: Only depth code 3'd3 (8 bits per pixel) draws. With any other code, no pixel or read is produced and `depth_err_o` is high. `depth_err_o` is updated at each frame boundary.
- R6: `irq_o` rises in the cycle that `frame_end_o` is high. A `reg_wr_i` or `pal_we_i` pulse clears it in the following cycle, and a simultaneous frame end takes priority over the clear. Reset clears it.
- R7: Colour, `valid_o`, `line_end_o` and `frame_end_o` are aligned. `line_end_o` marks the last pixel of each line, and `frame_end_o` marks the last pixel of the frame together with `line_end_o`.
- R8: Width, height, offset and blank are captured only in the idle cycle before a frame. A change made during a frame takes effect in the next frame.
- R9: During and straight after reset, `valid_o`, `rgb_o`, `irq_o`, `fb_rd_o` and `depth_err_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width_i | input | DIM_W | Active pixels per line |
| height_i | input | DIM_W | Active lines per frame |
| top_i | input | ADDR_W | Byte offset of the first pixel |
| blank_i | input | 1 | Force black output |
| depth_i | input | 3 | Depth code; 3'd3 selects 8 bits per pixel |
| reg_wr_i | input | 1 | Pulse for any register write; clears the interrupt |
| pal_we_i | input | 1 | Palette write strobe; also clears the interrupt |
| pal_idx_i | input | IDX_W | Palette entry written |
| pal_rgb_i | input | 3*CW | Palette colour written (R,G,B high to low) |
| fb_addr_o | output | ADDR_W | Frame buffer byte address |
| fb_rd_o | output | 1 | Frame buffer read strobe |
| fb_data_i | input | IDX_W | Frame buffer byte, one cycle after the address |
| rgb_o | output | 3*CW | Output colour |
| valid_o | output | 1 | Pixel valid |
| line_end_o | output | 1 | Last pixel of a line |
| frame_end_o | output | 1 | Last pixel of the frame |
| irq_o | output | 1 | Frame interrupt |
| depth_err_o | output | 1 | Unsupported depth code captured |

## Verification
The hardest case to reach from the ports is a configuration change that lands inside a running frame. The change must take effect one frame later and must not split the current frame. The stimulus lines up on the frame-end marker, because the next frame's settings have already been captured in that cycle. It moves the start offset at that point and checks that the whole following frame still reads from the old offset, then that the frame after it reads from the new one. The interrupt clear is timed the same way, just after a frame end, so that the clear does not fall in the same cycle as a new frame end.

// File: rtl/idx_scan_pkg.sv
`timescale 1ns/1ps
package idx_scan_pkg;
  localparam logic [2:0] DEPTH_CODE_8 = 3'd3;

  typedef struct packed {
    logic vld;
    logic le;
    logic fe;
    logic blank;
  } pix_mark_t;
endpackage

// File: rtl/idx_scan_walk.sv
`timescale 1ns/1ps
module idx_scan_walk
  import idx_scan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [ADDR_W-1:0] top_i,
  input  logic              blank_i,
  input  logic [2:0]        depth_i,
  output logic [ADDR_W-1:0] fb_addr_o,
  output logic              fb_rd_o,
  output pix_mark_t         mark_o,
  output logic              depth_err_o
);
  logic              run_q;
  logic [DIM_W-1:0]  w_q, h_q, x_q, y_q;
  logic [ADDR_W-1:0] addr_q;
  logic              blank_q, depth_err_q;
  logic              last_x, last_y;

  assign last_x = (x_q == w_q - 1'b1);
  assign last_y = (y_q == h_q - 1'b1);

  // idle cycle captures the frame settings; run walks pixels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      w_q         <= '0;
      h_q         <= '0;
      x_q         <= '0;
      y_q         <= '0;
      addr_q      <= '0;
      blank_q     <= 1'b0;
      depth_err_q <= 1'b0;
    end else if (!run_q) begin
      w_q         <= width_i;
      h_q         <= height_i;
      addr_q      <= top_i;
      blank_q     <= blank_i;
      x_q         <= '0;
      y_q         <= '0;
      depth_err_q <= (depth_i != DEPTH_CODE_8);
      run_q       <= (width_i != '0) && (height_i != '0) && (depth_i == DEPTH_CODE_8);
    end else begin
      addr_q <= addr_q + 1'b1;
      if (last_x) begin
        x_q <= '0;
        if (last_y) run_q <= 1'b0;
        else        y_q   <= y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  assign fb_addr_o    = addr_q;
  assign fb_rd_o      = run_q & ~blank_q;
  assign mark_o.vld   = run_q;
  assign mark_o.le    = run_q & last_x;
  assign mark_o.fe    = run_q & last_x & last_y;
  assign mark_o.blank = blank_q;
  assign depth_err_o  = depth_err_q;

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !(last_x && last_y)) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1))); // R1
  AST_FRAME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> ($stable(w_q) && $stable(h_q) && $stable(blank_q))); // R8
  AST_DEPTH_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_err_q |-> !run_q); // R5
  AST_ZERO_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (w_q != '0 && h_q != '0)); // R4
endmodule

// File: rtl/idx_scan_palette.sv
`timescale 1ns/1ps
module idx_scan_palette #(
  parameter int IDX_W = 8,
  parameter int CW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [3*CW-1:0]   wr_rgb_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [3*CW-1:0]   rd_rgb_o
);
  localparam int ENTRIES = 1 << IDX_W;

  // one bank per colour channel, red in the top slice
  for (genvar g = 0; g < 3; g++) begin : g_chan
    logic [CW-1:0] bank_q [ENTRIES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < ENTRIES; i++) bank_q[i] <= '0;
      end else if (we_i) begin
        bank_q[wr_idx_i] <= wr_rgb_i[(2-g)*CW +: CW];
      end
    end

    assign rd_rgb_o[(2-g)*CW +: CW] = bank_q[rd_idx_i];
  end
endmodule

// File: rtl/idx_scan_out.sv
`timescale 1ns/1ps
module idx_scan_out
  import idx_scan_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  pix_mark_t       mark_i,
  input  logic [3*CW-1:0] pal_rgb_i,
  input  logic            clr_i,
  output logic [3*CW-1:0] rgb_o,
  output logic            valid_o,
  output logic            line_end_o,
  output logic            frame_end_o,
  output logic            irq_o
);
  pix_mark_t       p1_q;
  logic [3*CW-1:0] rgb_q;
  logic            vld_q, le_q, fe_q, blk_q, irq_q;

  // p1 waits for the frame buffer byte; output stage looks it up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q  <= '0;
      rgb_q <= '0;
      vld_q <= 1'b0;
      le_q  <= 1'b0;
      fe_q  <= 1'b0;
      blk_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      p1_q  <= mark_i;
      rgb_q <= (p1_q.vld && !p1_q.blank) ? pal_rgb_i : '0;
      vld_q <= p1_q.vld;
      le_q  <= p1_q.le;
      fe_q  <= p1_q.fe;
      blk_q <= p1_q.blank;
      if (p1_q.fe)   irq_q <= 1'b1;
      else if (clr_i) irq_q <= 1'b0;
    end
  end

  assign rgb_o       = rgb_q;
  assign valid_o     = vld_q;
  assign line_end_o  = le_q;
  assign frame_end_o = fe_q;
  assign irq_o       = irq_q;

  AST_BLANK_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && blk_q) |-> (rgb_q == '0)); // R3
  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_q |-> irq_q); // R6
  AST_IRQ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !p1_q.fe) |=> !irq_q); // R6
  AST_MARK_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_q |-> (le_q && vld_q)); // R7
endmodule

// File: rtl/index_scanout.sv
`timescale 1ns/1ps
module index_scanout
  import idx_scan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 12,
  parameter int IDX_W  = 8,
  parameter int CW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [ADDR_W-1:0] top_i,
  input  logic              blank_i,
  input  logic [2:0]        depth_i,
  input  logic              reg_wr_i,
  input  logic              pal_we_i,
  input  logic [IDX_W-1:0]  pal_idx_i,
  input  logic [3*CW-1:0]   pal_rgb_i,
  output logic [ADDR_W-1:0] fb_addr_o,
  output logic              fb_rd_o,
  input  logic [IDX_W-1:0]  fb_data_i,
  output logic [3*CW-1:0]   rgb_o,
  output logic              valid_o,
  output logic              line_end_o,
  output logic              frame_end_o,
  output logic              irq_o,
  output logic              depth_err_o
);
  pix_mark_t       mark;
  logic [3*CW-1:0] lut_rgb;

  idx_scan_walk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .width_i     (width_i),
    .height_i    (height_i),
    .top_i       (top_i),
    .blank_i     (blank_i),
    .depth_i     (depth_i),
    .fb_addr_o   (fb_addr_o),
    .fb_rd_o     (fb_rd_o),
    .mark_o      (mark),
    .depth_err_o (depth_err_o)
  );

  idx_scan_palette #(.IDX_W(IDX_W), .CW(CW)) u_pal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (pal_we_i),
    .wr_idx_i (pal_idx_i),
    .wr_rgb_i (pal_rgb_i),
    .rd_idx_i (fb_data_i),
    .rd_rgb_o (lut_rgb)
  );

  idx_scan_out #(.CW(CW)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mark_i      (mark),
    .pal_rgb_i   (lut_rgb),
    .clr_i       (reg_wr_i | pal_we_i),
    .rgb_o       (rgb_o),
    .valid_o     (valid_o),
    .line_end_o  (line_end_o),
    .frame_end_o (frame_end_o),
    .irq_o       (irq_o)
  );
endmodule

// File: tb/index_scanout_test.sv
`timescale 1ns/1ps
module index_scanout_test;
  localparam int AW = 16, DW = 12, IW = 8, CW = 8;
  localparam int MEMSZ = 4096;
  localparam int NVEC = 6;
  // width, height, offset, blank
  localparam int VEC [NVEC][4] = '{
    '{4, 3, 0,    0},
    '{4, 3, 16,   0},
    '{5, 2, 100,  0},
    '{3, 4, 7,    1},
    '{8, 1, 2000, 0},
    '{1, 1, 4000, 0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [DW-1:0] width = '0, height = '0;
  logic [AW-1:0] top = '0;
  logic          blank = 1'b0;
  logic [2:0]    depth = 3'd3;
  logic          reg_wr = 1'b0, pal_we = 1'b0;
  logic [IW-1:0] pal_idx = '0;
  logic [23:0]   pal_rgb = '0;
  logic [AW-1:0] fb_addr;
  logic          fb_rd;
  logic [IW-1:0] fb_data;
  logic [23:0]   rgb;
  logic          valid, line_end, frame_end, irq, depth_err;

  index_scanout #(.ADDR_W(AW), .DIM_W(DW), .IDX_W(IW), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .width_i(width), .height_i(height),
    .top_i(top), .blank_i(blank), .depth_i(depth), .reg_wr_i(reg_wr),
    .pal_we_i(pal_we), .pal_idx_i(pal_idx), .pal_rgb_i(pal_rgb),
    .fb_addr_o(fb_addr), .fb_rd_o(fb_rd), .fb_data_i(fb_data),
    .rgb_o(rgb), .valid_o(valid), .line_end_o(line_end),
    .frame_end_o(frame_end), .irq_o(irq), .depth_err_o(depth_err)
  );

  logic [7:0]  mem [MEMSZ];
  logic [23:0] shadow [256];
  initial for (int i = 0; i < MEMSZ; i++) mem[i] = 8'((i * 37 + 11) & 255);
  always_ff @(posedge clk) fb_data <= mem[fb_addr[11:0]];

  int checks = 0, fails = 0;
  int vcnt = 0, rcnt = 0;
  always @(negedge clk) begin
    if (valid) vcnt++;
    if (fb_rd) rcnt++;
  end

  function automatic logic [23:0] pal_val(int i);
    return {i[7:0], ~i[7:0], i[7:0] ^ 8'h5a};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pal_write(int idx, logic [23:0] val);
    @(negedge clk);
    pal_we = 1'b1; pal_idx = IW'(idx); pal_rgb = val;
    shadow[idx] = val;
    @(negedge clk);
    pal_we = 1'b0;
  endtask

  task automatic wait_fe();
    int n = 0;
    @(negedge clk);
    while (!frame_end && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) chk(0, "R7", "frame end timeout", 0, 1);
  endtask

  task automatic check_frame(int w, int h, int t, int b, string req);
    int pix = 0, bad = 0, rds = 0, n = 0;
    logic [23:0] exp_c;
    while (pix < w * h && n < 4000) begin
      @(negedge clk);
      n++;
      if (fb_rd) rds++;
      if (valid) begin
        exp_c = b ? 24'h0 : shadow[mem[t + pix]];
        if (rgb !== exp_c) bad++;
        if (line_end !== ((pix % w) == w - 1)) bad++;
        if (frame_end !== (pix == w * h - 1)) bad++;
        pix++;
      end
    end
    chk(pix == w * h, req, "pixel count", pix, w * h);
    chk(bad == 0, req, "pixel/marker mismatches (R2 R7)", bad, 0);
    chk(rds == (b ? 0 : w * h), b ? "R3" : "R1", "read strobes", rds, b ? 0 : w * h);
    chk(irq === 1'b1, "R6", "irq at frame end", irq, 1);
  endtask

  task automatic set_cfg(int w, int h, int t, int b);
    @(negedge clk);
    width = DW'(w); height = DW'(h); top = AW'(t); blank = b[0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", "run timed out", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    chk(valid == 0 && rgb == 0, "R9", "valid/rgb in reset", {valid, rgb}, 0);
    chk(irq == 0 && fb_rd == 0 && depth_err == 0, "R9", "irq/rd/err in reset",
        {irq, fb_rd, depth_err}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(valid == 0 && irq == 0 && fb_rd == 0, "R9", "state after reset",
        {valid, irq, fb_rd}, 0);

    for (int i = 0; i < 256; i++) pal_write(i, pal_val(i));

    // table of frames: raster fetch, lookup, panning, blank
    for (int v = 0; v < NVEC; v++) begin
      set_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      wait_fe();
      check_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3],
                  VEC[v][3] != 0 ? "R3" : "R1");
    end

    // R8: offset moved after capture does not touch the frame already set up
    set_cfg(4, 3, 0, 0);
    wait_fe();
    check_frame(4, 3, 0, 0, "R8");
    top = AW'(500);
    check_frame(4, 3, 0, 0, "R8");
    wait_fe();
    check_frame(4, 3, 500, 0, "R8");

    // R6: clear by register write, then by palette write
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk(irq == 0, "R6", "irq cleared by reg write", irq, 0);
    wait_fe();
    chk(irq == 1, "R6", "irq set again", irq, 1);
    pal_write(3, pal_val(3));
    chk(irq == 0, "R6", "irq cleared by palette write", irq, 0);

    // R2: rewrite an entry in use and see the new colour
    pal_write(mem[500], 24'h123456);
    wait_fe();
    check_frame(4, 3, 500, 0, "R2");

    // R4: zero width, then zero height
    set_cfg(0, 3, 0, 0);
    repeat (40) @(negedge clk);
    reg_wr = 1'b1; @(negedge clk); reg_wr = 1'b0;
    vcnt = 0; rcnt = 0;
    repeat (60) @(negedge clk);
    chk(vcnt == 0 && rcnt == 0, "R4", "zero width output", vcnt + rcnt, 0);
    chk(irq == 0, "R4", "zero width irq", irq, 0);
    set_cfg(4, 0, 0, 0);
    vcnt = 0; rcnt = 0;
    repeat (60) @(negedge clk);
    chk(vcnt == 0 && rcnt == 0 && irq == 0, "R4", "zero height output",
        vcnt + rcnt + irq, 0);

    // R5: unsupported depth code
    set_cfg(4, 3, 0, 0);
    depth = 3'd5;
    repeat (5) @(negedge clk);
    vcnt = 0; rcnt = 0;
    repeat (60) @(negedge clk);
    chk(depth_err == 1, "R5", "error flag", depth_err, 1);
    chk(vcnt == 0 && rcnt == 0, "R5", "no output with bad depth", vcnt + rcnt, 0);
    depth = 3'd3;
    wait_fe();
    chk(depth_err == 0, "R5", "error flag cleared", depth_err, 0);
    check_frame(4, 3, 0, 0, "R5");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule